// File: doc/BRIEF.md
# Configurable serial byte receiver

This block turns a clocked serial data stream into whole bytes. A data line is sampled against a serial clock that comes from outside. Sampling is allowed only while the port is selected. Each completed byte appears on a parallel output together with a strobe that is high for one cycle. The block passes bytes through in the order they arrive.

Three run-time mode inputs control reception:

- the serial clock edge used for sampling;
- whether each byte travels most significant or least significant bit first;
- whether the port uses its own select line or follows the inverse of a select line belonging to a neighbouring control port.

All serial inputs are brought into the system clock domain through a two-stage synchronizer. Clock edges are found there, so the serial clock may run at no more than a quarter of the system clock.

Top module: `sdi_byte_rx`

## Requirements
- R1: With `cfg_fall_edge` = 0, a data bit is captured when the synchronized serial clock goes from 0 to 1.
- R2: With `cfg_fall_edge` = 1, a data bit is captured when the synchronized serial clock goes from 1 to 0.
- R3: With `cfg_lsb_first` = 0, the first captured bit of a byte lands in `byte_o[7]` and the eighth lands in `byte_o[0]`.
- R4: With `cfg_lsb_first` = 1, the first captured bit lands in `byte_o[0]` and the eighth lands in `byte_o[7]`.
- R5: Consecutive bytes are delivered in their arrival order, and the eighth captured bit always completes a byte.
- R6: Unless both `cfg_share` and `cfg_native` are 1, the port is selected while `dsel_n_i` is 0, and `csel_n_i` has no effect.
- R7: When `cfg_share` and `cfg_native` are both 1, the port is selected while `csel_n_i` is 1, and `dsel_n_i` has no effect.
- R8: While the port is not selected, the bit count returns to zero and a partly received byte is discarded. A later byte is then assembled from fresh bits.
- R9: `byte_vld_o` is high for exactly one system clock cycle, three system clocks after the completing serial clock edge appears at the pins. `byte_o` changes only in that cycle and otherwise holds the last byte.
- R10: After reset, `byte_o` is 0 and `byte_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock |
| sdat_i | input | 1 | Serial data |
| dsel_n_i | input | 1 | Dedicated select for this port, active low |
| csel_n_i | input | 1 | Control port select, active low |
| cfg_fall_edge | input | 1 | 1 = sample on the falling serial clock edge |
| cfg_lsb_first | input | 1 | 1 = least significant bit first |
| cfg_share | input | 1 | Request to share the control port's select |
| cfg_native | input | 1 | Enables sharing together with `cfg_share` |
| byte_o | output | 8 | Last completed byte |
| byte_vld_o | output | 1 | One-cycle strobe for a new byte |

## Verification
Two things can happen in the same cycle: a sampling edge arrives, and the select goes inactive. When they coincide, the deselect must win and no bit may be counted. The bench provokes this by dropping the select in the middle of a byte, in both dedicated and shared mode. It then sends a complete byte and checks that it comes out whole, with none of the earlier partial bits mixed in. A behavioural model steps through the same pin values and predicts the strobe and the byte three cycles later. The bench compares the model with the design on every clock.

// File: rtl/sdi_byte_rx.sv
module sdi_byte_rx #(
  parameter int W           = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_i,
  input  logic         sdat_i,
  input  logic         dsel_n_i,
  input  logic         csel_n_i,
  input  logic         cfg_fall_edge,
  input  logic         cfg_lsb_first,
  input  logic         cfg_share,
  input  logic         cfg_native,
  output logic [W-1:0] byte_o,
  output logic         byte_vld_o
);
  localparam int CW = $clog2(W);

  logic [3:0]    sq [SYNC_STAGES];
  logic [3:0]    s;
  logic          sclk_d;
  logic [CW-1:0] cnt;
  logic [W-1:0]  sh;
  logic [W-1:0]  nxt;
  logic          share_on, sel, smp_edge, take, at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_STAGES; i++) sq[i] <= '0;
    end else begin
      sq[0] <= {csel_n_i, dsel_n_i, sdat_i, sclk_i};
      for (int i = 1; i < SYNC_STAGES; i++) sq[i] <= sq[i-1];
    end
  end

  assign s        = sq[SYNC_STAGES-1];
  assign share_on = cfg_share & cfg_native;
  assign sel      = share_on ? s[3] : ~s[2];
  assign smp_edge = cfg_fall_edge ? (sclk_d & ~s[0]) : (~sclk_d & s[0]);
  assign take     = sel & smp_edge;
  assign nxt      = cfg_lsb_first ? {s[1], sh[W-1:1]} : {sh[W-2:0], s[1]};
  assign at_last  = (cnt == CW'(W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d     <= 1'b0;
      cnt        <= '0;
      sh         <= '0;
      byte_o     <= '0;
      byte_vld_o <= 1'b0;
    end else begin
      sclk_d     <= s[0];
      byte_vld_o <= 1'b0;
      if (!sel) begin
        cnt <= '0;
      end else if (take) begin
        sh <= nxt;
        if (at_last) begin
          cnt        <= '0;
          byte_o     <= nxt;
          byte_vld_o <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |=> !byte_vld_o);

  p_byte_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_o) |-> byte_vld_o);

  p_strobe_after_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_o |-> $past(take));

  p_deselect_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> (cnt == '0));

  p_count_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !take) |=> $stable(cnt));
endmodule

// File: tb/sdi_byte_rx_bench.sv
module sdi_byte_rx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdat = 1'b0, dsel_n = 1'b1, csel_n = 1'b0;
  logic c_fall = 1'b0, c_lsb = 1'b0, c_share = 1'b0, c_native = 1'b0;
  logic [7:0] byte_o;
  logic       byte_vld_o;

  int compared = 0, mismatched = 0;
  string cur_req = "R10";

  int m_cnt = 0, m_sh = 0;
  logic m_prev = 1'b0;
  bit   dv [3];
  int   db [3];
  int   exp_byte = 0;

  always #2 clk = ~clk;

  sdi_byte_rx u_sdi_byte_rx (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdat_i(sdat),
    .dsel_n_i(dsel_n), .csel_n_i(csel_n),
    .cfg_fall_edge(c_fall), .cfg_lsb_first(c_lsb),
    .cfg_share(c_share), .cfg_native(c_native),
    .byte_o(byte_o), .byte_vld_o(byte_vld_o));

  task automatic check(string req, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    bit sel, samp, nv;
    int nb;
    sel  = (c_share && c_native) ? (csel_n == 1'b1) : (dsel_n == 1'b0);
    samp = sel && (c_fall ? (m_prev && !sclk) : (!m_prev && sclk));
    nv = 0; nb = 0;
    if (!sel) m_cnt = 0;
    else if (samp) begin
      m_sh = c_lsb ? ((m_sh >> 1) | (int'(sdat) << 7)) : (((m_sh << 1) | int'(sdat)) & 255);
      m_cnt++;
      if (m_cnt == 8) begin m_cnt = 0; nv = 1; nb = m_sh; end
    end
    m_prev = sclk;
    dv[2] = dv[1]; db[2] = db[1];
    dv[1] = dv[0]; db[1] = db[0];
    dv[0] = nv;    db[0] = nb;
    @(negedge clk);
    if (dv[2]) exp_byte = db[2];
    check({cur_req, " strobe"}, int'(byte_vld_o), int'(dv[2]));
    check({cur_req, " byte"}, int'(byte_o), exp_byte);
  endtask

  task automatic steps(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic send_bit(bit b);
    sdat = b;
    steps(2);
    sclk = ~c_fall;
    steps(2);
    sclk = c_fall;
    steps(2);
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) send_bit(c_lsb ? v[i] : v[7-i]);
  endtask

  task automatic set_mode(bit fall, bit lsb, bit share, bit native);
    dsel_n = 1'b1; csel_n = 1'b0;
    steps(4);
    c_fall = fall; c_lsb = lsb; c_share = share; c_native = native;
    sclk = fall;
    steps(4);
  endtask

  initial begin
    for (int i = 0; i < 3; i++) begin dv[i] = 0; db[i] = 0; end
    repeat (3) @(negedge clk);
    check("R10 reset byte", int'(byte_o), 0);
    check("R10 reset strobe", int'(byte_vld_o), 0);
    rst_n = 1'b1;
    steps(4);

    cur_req = "R1 R3 R5";
    dsel_n = 1'b0; steps(2);
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h01);
    steps(4);

    cur_req = "R4";
    set_mode(0, 1, 0, 0);
    dsel_n = 1'b0; steps(2);
    send_byte(8'h80); send_byte(8'h6E);
    steps(4);

    cur_req = "R2 R3";
    set_mode(1, 0, 0, 0);
    dsel_n = 1'b0; steps(2);
    send_byte(8'hC3);
    steps(4);

    cur_req = "R2 R4";
    set_mode(1, 1, 0, 0);
    dsel_n = 1'b0; steps(2);
    send_byte(8'h12);
    steps(4);

    cur_req = "R8";
    set_mode(0, 0, 0, 0);
    dsel_n = 1'b0; steps(2);
    send_bit(1); send_bit(1); send_bit(1);
    dsel_n = 1'b1; steps(4);
    dsel_n = 1'b0; steps(2);
    send_byte(8'h5A);
    steps(4);

    cur_req = "R6";
    set_mode(0, 0, 1, 0);
    csel_n = 1'b1; dsel_n = 1'b1; steps(2);
    send_byte(8'hFF);
    dsel_n = 1'b0; steps(2);
    send_byte(8'h47);
    steps(4);

    cur_req = "R7";
    set_mode(0, 1, 1, 1);
    dsel_n = 1'b1; csel_n = 1'b1; steps(2);
    send_byte(8'h99);
    send_bit(0); send_bit(1);
    csel_n = 1'b0; steps(4);
    dsel_n = 1'b0; send_byte(8'hEE);
    csel_n = 1'b1; dsel_n = 1'b0; steps(2);
    send_byte(8'h2D);
    steps(6);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule